// File: doc/BRIEF.md
# Output Emergency High-Impedance Controller

This block releases timer output pins into a high-impedance state as soon as an emergency is seen, so that a power stage is left undriven without software having to act first. It watches four active-low shutdown request inputs, a comparator that notices when both halves of a complementary output pair are active together, and software force requests. From these it drives one tri-state request per pin for three complementary high-current pairs (six pins) and four single-channel outputs.

The pins fall into two independent shutdown domains. The pairs react to shutdown inputs 0, 1 and 2, to the output-short flag when that trigger is enabled, and to one shared software request. The single-channel pins react only to shutdown input 3 when its separate enable is set, and to one software request per channel. Each pin also has its own enable, and a pin is only forced while its function select says general I/O or timer output. Flags are sticky: software reads a flag as 1 and then writes 0 to clear it.

A small register interface with four word addresses holds the flags, the detection configuration, the pin enables and the software requests. The pads, the pin multiplexer and the PWM timer are outside the block. Their state reaches it as the function select codes and the raw pair output levels.

Top module: `emhz_ctrl`

## Requirements
- R1: Reset (synchronous, active low) clears every flag, enable, configuration bit and software request, so all `pin_hiz` bits are 0 and every register reads 0 after reset.
- R2: In edge mode (config bit for that input = 0), a high-to-low change on `shd_n[i]` sets flag bit i at address 0. The inputs pass a two-stage synchronizer, so `pin_hiz` follows on the third rising clock edge after the change.
- R3: Pair p forces both of its pins (`pin_hiz[2p]` and `pin_hiz[2p+1]`) when pair enable bit p at address 2 is set and at least one of these holds: flag 0, 1 or 2 is set; the short flag (address 0 bit 4) is set together with short enable (address 1 bit 6); the shared software request (address 3 bit 0) is set.
- R4: Single pin k (`pin_hiz[6+k]`) is forced when enable bit 3+k at address 2 is set and either flag 3 is set together with its enable (address 1 bit 5) or software request bit 1+k at address 3 is set. Flag 3 without its enable forces nothing.
- R5: The short flag sets on the clock edge where, for an enabled pair, `pwm_hi` and `pwm_lo` are both 1. It never affects single-channel pins, and it does not set for a pair whose enable is clear.
- R6: A pin can be forced only while its 2-bit function code in `pin_fn` is 00 (general I/O) or 01 (timer output). With 10 or 11 its `pin_hiz` bit stays 0.
- R7: Flags stay set until cleared. Writing 0 to a flag bit at address 0 clears it only if that flag was read as 1 since the last write to address 0. A write of 0 with no such read, or a write of 1, leaves the flag set.
- R8: If a clear lands on the same clock edge as a new trigger event for that flag, the flag stays set.
- R9: In low-level mode (config bit for that input = 1), the flag sets once the synchronized input has been low for 8 consecutive samples (address 1 bit 4 = 0) or 16 samples (bit 4 = 1). This is the 10th or 18th rising edge after the input goes low. A shorter low pulse sets nothing, and a falling edge alone sets nothing.
- R10: `pin_hiz` is combinational from the registered state. A register write or a flag clear takes effect right after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shd_n | input | 4 | Asynchronous active-low shutdown requests |
| pwm_hi | input | 3 | High-side level of each complementary pair |
| pwm_lo | input | 3 | Low-side level of each complementary pair |
| pin_fn | input | 20 | 2-bit function code per pin, pin j at bits [2j+1:2j] |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| pin_hiz | output | 10 | Per-pin high-impedance request; pairs at 0..5, single pins at 6..9 |

## Verification
Register-driven results (enables, software requests, configuration) are due right after the edge that writes them, so the bench samples at the next falling edge. The short flag acts one edge after the pair levels are applied. An edge-mode flag acts on the third edge after a shutdown input falls. A level-mode flag acts on the 10th or 18th edge, and the bench also checks one edge earlier to prove it has not fired too soon. All stimulus changes on falling edges, and every sample is taken at a falling edge after the counted number of rising edges.

// File: rtl/emhz_pkg.sv
// Shared constants for the emergency high-impedance controller.
// Assumes a 2-bit register word address and a 2-bit pin function code.
package emhz_pkg;

    // register word addresses
    localparam logic [1:0] A_FLAG  = 2'd0;
    localparam logic [1:0] A_CFG   = 2'd1;
    localparam logic [1:0] A_PINEN = 2'd2;
    localparam logic [1:0] A_SWREQ = 2'd3;

    // pin function codes for which the block may float the pin
    localparam logic [1:0] FN_GPIO  = 2'b00;
    localparam logic [1:0] FN_TIMER = 2'b01;

    // true when the selected pin function lets the block take the pin
    function automatic logic fn_drives(input logic [1:0] code);
        return (code == FN_GPIO) || (code == FN_TIMER);
    endfunction

endpackage

// File: rtl/emhz_shd_detect.sv
// One shutdown input: synchronizer, falling-edge detector and low-level counter.
// Assumes the input idles high; set_evt is a one-cycle (edge) or held (level) request.
module emhz_shd_detect #(
    parameter int SYNC_STAGES = 2,
    parameter int LVL_SHORT   = 8,
    parameter int LVL_LONG    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic level_mode,
    input  logic long_cnt,
    output logic set_evt
);
    localparam int CNT_W = $clog2(LVL_LONG);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   smp;
    logic                   prev_q;
    logic [CNT_W-1:0]       low_cnt_q;
    logic [CNT_W-1:0]       lim_m1;

    // bring the asynchronous input into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    assign smp = sync_q[SYNC_STAGES-1];

    // hold the previous synchronized sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= smp;
    end

    // count consecutive low samples, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                low_cnt_q <= '0;
        else if (smp)              low_cnt_q <= '0;
        else if (low_cnt_q != '1)  low_cnt_q <= low_cnt_q + 1'b1;
    end

    // pick the low-sample threshold and form the trigger
    always_comb begin
        lim_m1  = long_cnt ? CNT_W'(LVL_LONG - 1) : CNT_W'(LVL_SHORT - 1);
        set_evt = level_mode ? (!smp && (low_cnt_q >= lim_m1))
                             : (prev_q && !smp);
    end

endmodule

// File: rtl/emhz_regs.sv
// Register file: sticky flags with read-then-write-0 clear, config, enables, requests.
// Assumes all fields fit in DATA_W bits; a set event beats a coincident clear.
module emhz_regs
    import emhz_pkg::*;
#(
    parameter int N_SHD  = 4,
    parameter int N_PAIR = 3,
    parameter int N_SGL  = 4,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [1:0]              bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [N_SHD-1:0]        in_set,
    input  logic                    sh_set,
    output logic [N_SHD:0]          flags,
    output logic [N_SHD-1:0]        mode,
    output logic                    cnt_long,
    output logic                    in_en_last,
    output logic                    sh_en,
    output logic [N_PAIR+N_SGL-1:0] pin_en,
    output logic [N_SGL:0]          sw_req
);
    localparam int N_FLG = N_SHD + 1;
    localparam int N_CFG = N_SHD + 3;
    localparam int N_EN  = N_PAIR + N_SGL;
    localparam int N_SW  = N_SGL + 1;

    logic [N_FLG-1:0] flg_q, armed_q, clr, set_ev;
    logic [N_CFG-1:0] cfg_q;
    logic [N_EN-1:0]  en_q;
    logic [N_SW-1:0]  sw_q;
    logic             wr_flag, rd_flag;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata;
    assign wr_flag = bus_wr && (bus_addr == A_FLAG);
    assign rd_flag = bus_rd && (bus_addr == A_FLAG);
    assign set_ev  = {sh_set, in_set};
    assign clr     = {N_FLG{wr_flag}} & ~bus_wdata[N_FLG-1:0] & armed_q;

    // sticky flags: set wins, armed zero-write clears
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= set_ev | (flg_q & ~clr);
    end

    // remember which flags software has seen as 1
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= '0;
        else if (rd_flag) armed_q <= flg_q;
        else if (wr_flag) armed_q <= '0;
    end

    // configuration, pin enable and software request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            en_q  <= '0;
            sw_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CFG:   cfg_q <= bus_wdata[N_CFG-1:0];
                A_PINEN: en_q  <= bus_wdata[N_EN-1:0];
                A_SWREQ: sw_q  <= bus_wdata[N_SW-1:0];
                default: ;
            endcase
        end
    end

    // read data mux, zero when idle
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_FLAG:  bus_rdata[N_FLG-1:0] = flg_q;
                A_CFG:   bus_rdata[N_CFG-1:0] = cfg_q;
                A_PINEN: bus_rdata[N_EN-1:0]  = en_q;
                default: bus_rdata[N_SW-1:0]  = sw_q;
            endcase
        end
    end

    assign flags      = flg_q;
    assign mode       = cfg_q[N_SHD-1:0];
    assign cnt_long   = cfg_q[N_SHD];
    assign in_en_last = cfg_q[N_SHD+1];
    assign sh_en      = cfg_q[N_SHD+2];
    assign pin_en     = en_q;
    assign sw_req     = sw_q;

endmodule

// File: rtl/emhz_hz_gate.sv
// Output-short comparator and the two shutdown domains' per-pin gating.
// Assumes pair p drives pins 2p and 2p+1 and single k drives pin 2*N_PAIR+k.
module emhz_hz_gate
    import emhz_pkg::*;
#(
    parameter int N_SHD  = 4,
    parameter int N_PAIR = 3,
    parameter int N_SGL  = 4
) (
    input  logic [N_SHD:0]              flags,
    input  logic                        sh_en,
    input  logic                        in_en_last,
    input  logic [N_PAIR+N_SGL-1:0]     pin_en,
    input  logic [N_SGL:0]              sw_req,
    input  logic [2*(2*N_PAIR+N_SGL)-1:0] pin_fn,
    input  logic [N_PAIR-1:0]           pwm_hi,
    input  logic [N_PAIR-1:0]           pwm_lo,
    output logic                        sh_set,
    output logic [2*N_PAIR+N_SGL-1:0]   pin_hiz
);
    logic hc_trig;
    logic sg_base;

    // both halves of an enabled pair active together
    assign sh_set = |(pwm_hi & pwm_lo & pin_en[N_PAIR-1:0]);

    // trigger of each shutdown domain
    assign hc_trig = (|flags[N_SHD-2:0]) | (flags[N_SHD] & sh_en) | sw_req[0];
    assign sg_base = flags[N_SHD-1] & in_en_last;

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        // both pins of a pair share the pair enable
        assign pin_hiz[2*p]   = pin_en[p] & hc_trig & fn_drives(pin_fn[4*p+1 -: 2]);
        assign pin_hiz[2*p+1] = pin_en[p] & hc_trig & fn_drives(pin_fn[4*p+3 -: 2]);
    end

    for (genvar k = 0; k < N_SGL; k++) begin : g_sgl
        // single channel: own enable, shared input flag or own request
        localparam int PIN = 2*N_PAIR + k;
        assign pin_hiz[PIN] = pin_en[N_PAIR+k] & (sg_base | sw_req[1+k])
                              & fn_drives(pin_fn[2*PIN+1 -: 2]);
    end

endmodule

// File: rtl/emhz_ctrl.sv
// Top: emergency high-impedance controller for timer output pins.
// Assumes shd_n idles high; pin_hiz is combinational from registered state.
module emhz_ctrl #(
    parameter int N_SHD       = 4,
    parameter int N_PAIR      = 3,
    parameter int N_SGL       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int LVL_SHORT   = 8,
    parameter int LVL_LONG    = 16,
    parameter int DATA_W      = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_SHD-1:0]                shd_n,
    input  logic [N_PAIR-1:0]               pwm_hi,
    input  logic [N_PAIR-1:0]               pwm_lo,
    input  logic [2*(2*N_PAIR+N_SGL)-1:0]   pin_fn,
    input  logic                            bus_wr,
    input  logic                            bus_rd,
    input  logic [1:0]                      bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    output logic [2*N_PAIR+N_SGL-1:0]       pin_hiz
);
    localparam int N_EN = N_PAIR + N_SGL;

    logic [N_SHD-1:0] in_set;
    logic [N_SHD-1:0] mode;
    logic             sh_set;
    logic [N_SHD:0]   flags;
    logic             cnt_long;
    logic             in_en_last;
    logic             sh_en;
    logic [N_EN-1:0]  pin_en;
    logic [N_SGL:0]   sw_req;

    for (genvar g = 0; g < N_SHD; g++) begin : g_det
        // one detector per shutdown input
        emhz_shd_detect #(
            .SYNC_STAGES (SYNC_STAGES),
            .LVL_SHORT   (LVL_SHORT),
            .LVL_LONG    (LVL_LONG)
        ) u_det (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_n      (shd_n[g]),
            .level_mode (mode[g]),
            .long_cnt   (cnt_long),
            .set_evt    (in_set[g])
        );
    end

    emhz_regs #(
        .N_SHD  (N_SHD),
        .N_PAIR (N_PAIR),
        .N_SGL  (N_SGL),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .in_set     (in_set),
        .sh_set     (sh_set),
        .flags      (flags),
        .mode       (mode),
        .cnt_long   (cnt_long),
        .in_en_last (in_en_last),
        .sh_en      (sh_en),
        .pin_en     (pin_en),
        .sw_req     (sw_req)
    );

    emhz_hz_gate #(
        .N_SHD  (N_SHD),
        .N_PAIR (N_PAIR),
        .N_SGL  (N_SGL)
    ) u_gate (
        .flags      (flags),
        .sh_en      (sh_en),
        .in_en_last (in_en_last),
        .pin_en     (pin_en),
        .sw_req     (sw_req),
        .pin_fn     (pin_fn),
        .pwm_hi     (pwm_hi),
        .pwm_lo     (pwm_lo),
        .sh_set     (sh_set),
        .pin_hiz    (pin_hiz)
    );

endmodule

// File: rtl/emhz_chk.sv
// Checker for emhz_ctrl, bound to every instance of the top.
// Assumes the pin numbering of emhz_hz_gate and the flag layout of emhz_regs.
module emhz_chk
    import emhz_pkg::*;
#(
    parameter int N_SHD  = 4,
    parameter int N_PAIR = 3,
    parameter int N_SGL  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_wr,
    input logic [1:0]                    bus_addr,
    input logic [2*(2*N_PAIR+N_SGL)-1:0] pin_fn,
    input logic [2*N_PAIR+N_SGL-1:0]     pin_hiz,
    input logic [N_SHD:0]                flags,
    input logic [N_PAIR+N_SGL-1:0]       pin_en,
    input logic [N_SGL:0]                sw_req,
    input logic                          in_en_last
);
    localparam int N_PIN = 2*N_PAIR + N_SGL;

    logic [N_PIN-1:0] fn_bad;
    logic [N_PIN-1:0] may_float;
    logic             hc_any;

    // necessary conditions for each pin to be floated
    always_comb begin
        hc_any = (|flags[N_SHD-2:0]) | flags[N_SHD] | sw_req[0];
        for (int j = 0; j < N_PIN; j++) fn_bad[j] = !fn_drives(pin_fn[2*j+1 -: 2]);
        for (int p = 0; p < N_PAIR; p++) begin
            may_float[2*p]   = pin_en[p] & hc_any;
            may_float[2*p+1] = pin_en[p] & hc_any;
        end
        for (int k = 0; k < N_SGL; k++)
            may_float[2*N_PAIR+k] = pin_en[N_PAIR+k]
                                    & ((flags[N_SHD-1] & in_en_last) | sw_req[1+k]);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (pin_hiz == '0));

    // R6
    fn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_hiz & fn_bad) == '0);

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~flags & $past(flags))) |-> $past(bus_wr && (bus_addr == A_FLAG)));

    // R3
    pair_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_hiz[2*N_PAIR-1:0] & ~may_float[2*N_PAIR-1:0]) == '0);

    // R4
    sgl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_hiz[N_PIN-1:2*N_PAIR] & ~may_float[N_PIN-1:2*N_PAIR]) == '0);

endmodule

bind emhz_ctrl emhz_chk #(
    .N_SHD  (N_SHD),
    .N_PAIR (N_PAIR),
    .N_SGL  (N_SGL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .pin_fn     (pin_fn),
    .pin_hiz    (pin_hiz),
    .flags      (flags),
    .pin_en     (pin_en),
    .sw_req     (sw_req),
    .in_en_last (in_en_last)
);

// File: tb/sim_emhz_ctrl.sv
`timescale 1ns/1ps
module sim_emhz_ctrl;
    import emhz_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  shd_n = 4'hF;
    logic [2:0]  pwm_hi = '0;
    logic [2:0]  pwm_lo = '0;
    logic [19:0] pin_fn = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [9:0]  pin_hiz;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    emhz_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .shd_n(shd_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .pin_fn(pin_fn), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_hiz(pin_hiz)
    );

    // {pin enables[6:0], sw requests[4:0], fn code[1:0], expected pin_hiz[9:0]}
    localparam logic [23:0] VEC [9] = '{
        {7'h7F, 5'h00, 2'b00, 10'h000},
        {7'h7F, 5'h01, 2'b00, 10'h03F},
        {7'h05, 5'h01, 2'b01, 10'h033},
        {7'h78, 5'h1E, 2'b00, 10'h3C0},
        {7'h28, 5'h06, 2'b00, 10'h040},
        {7'h7F, 5'h1F, 2'b10, 10'h000},
        {7'h7F, 5'h1F, 2'b11, 10'h000},
        {7'h7F, 5'h1F, 2'b01, 10'h3FF},
        {7'h02, 5'h10, 2'b00, 10'h000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic clear_all();
        reg_rd(A_FLAG, rv);
        reg_wr(A_FLAG, 8'h00);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        // R1 reset state
        wait_n(1);
        chk("R1 hiz after reset", 16'(pin_hiz), 16'h0);
        for (int a = 0; a < 4; a++) begin
            reg_rd(2'(a), rv);
            chk("R1 register after reset", 16'(rv), 16'h0);
        end

        // R3 R4 R6 table of enables, requests and function codes
        for (int i = 0; i < 9; i++) begin
            pin_fn = {10{VEC[i][11:10]}};
            reg_wr(A_PINEN, {1'b0, VEC[i][23:17]});
            reg_wr(A_SWREQ, {3'b0, VEC[i][16:12]});
            chk("R3 R4 R6 vector", 16'(pin_hiz), 16'(VEC[i][9:0]));
        end
        reg_wr(A_SWREQ, 8'h00);
        pin_fn = '0;

        // R2 edge detect on input 1, timing of the third edge
        reg_wr(A_PINEN, 8'h7F);
        reg_wr(A_CFG, 8'h00);
        shd_n[1] = 1'b0;
        wait_n(2);
        chk("R2 not yet after two edges", 16'(pin_hiz), 16'h0);
        wait_n(1);
        chk("R2 pairs forced on third edge", 16'(pin_hiz), 16'h03F);
        // R7 zero write without prior read leaves the flag
        reg_wr(A_FLAG, 8'h00);
        chk("R7 unarmed clear ignored", 16'(pin_hiz), 16'h03F);
        reg_rd(A_FLAG, rv);
        chk("R2 flag readback", 16'(rv), 16'h02);
        reg_wr(A_FLAG, 8'hFF);
        reg_rd(A_FLAG, rv);
        chk("R7 write one ignored", 16'(rv), 16'h02);
        reg_wr(A_FLAG, 8'h00);
        chk("R10 release after clear", 16'(pin_hiz), 16'h0);
        reg_rd(A_FLAG, rv);
        chk("R7 flag cleared", 16'(rv), 16'h0);
        shd_n[1] = 1'b1;
        wait_n(4);

        // R4 input 3 needs its own enable
        shd_n[3] = 1'b0;
        wait_n(3);
        chk("R4 flag 3 without enable", 16'(pin_hiz), 16'h0);
        reg_wr(A_CFG, 8'h20);
        chk("R4 flag 3 with enable", 16'(pin_hiz), 16'h3C0);
        reg_rd(A_FLAG, rv);
        chk("R4 flag 3 readback", 16'(rv), 16'h08);
        shd_n[3] = 1'b1;
        reg_wr(A_FLAG, 8'h00);
        reg_wr(A_CFG, 8'h00);
        wait_n(4);

        // R5 output short on pair 1
        reg_wr(A_CFG, 8'h40);
        pwm_hi = 3'b010; pwm_lo = 3'b010;
        wait_n(1);
        chk("R5 short forces pairs only", 16'(pin_hiz), 16'h03F);
        pwm_hi = 3'b000; pwm_lo = 3'b000;
        reg_wr(A_CFG, 8'h00);
        chk("R5 short flag gated by enable", 16'(pin_hiz), 16'h0);
        reg_rd(A_FLAG, rv);
        chk("R5 short flag readback", 16'(rv), 16'h10);
        reg_wr(A_FLAG, 8'h00);
        reg_wr(A_PINEN, 8'h78);
        pwm_hi = 3'b001; pwm_lo = 3'b001;
        wait_n(1);
        pwm_hi = 3'b000; pwm_lo = 3'b000;
        reg_rd(A_FLAG, rv);
        chk("R5 disabled pair sets nothing", 16'(rv), 16'h0);
        reg_wr(A_PINEN, 8'h7F);

        // R8 clear coincides with a new edge on input 0
        shd_n[0] = 1'b0;
        wait_n(3);
        reg_rd(A_FLAG, rv);
        chk("R8 first event", 16'(rv), 16'h01);
        shd_n[0] = 1'b1;
        wait_n(4);
        shd_n[0] = 1'b0;
        wait_n(2);
        bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'h00;
        wait_n(1);
        bus_wr = 1'b0;
        reg_rd(A_FLAG, rv);
        chk("R8 set beats clear", 16'(rv), 16'h01);
        reg_wr(A_FLAG, 8'h00);
        reg_rd(A_FLAG, rv);
        chk("R8 later clear works", 16'(rv), 16'h0);
        shd_n[0] = 1'b1;
        wait_n(4);

        // R9 level mode on input 2, count of 8
        reg_wr(A_CFG, 8'h04);
        shd_n[2] = 1'b0;
        wait_n(5);
        shd_n[2] = 1'b1;
        wait_n(4);
        reg_rd(A_FLAG, rv);
        chk("R9 short pulse and edge ignored", 16'(rv), 16'h0);
        shd_n[2] = 1'b0;
        wait_n(9);
        chk("R9 eight count not yet", 16'(pin_hiz), 16'h0);
        wait_n(1);
        chk("R9 eight count reached", 16'(pin_hiz), 16'h03F);
        shd_n[2] = 1'b1;
        wait_n(4);
        clear_all();
        // R9 count of 16
        reg_wr(A_CFG, 8'h14);
        shd_n[2] = 1'b0;
        wait_n(17);
        chk("R9 sixteen count not yet", 16'(pin_hiz), 16'h0);
        wait_n(1);
        chk("R9 sixteen count reached", 16'(pin_hiz), 16'h03F);
        shd_n[2] = 1'b1;
        wait_n(4);
        clear_all();
        chk("R10 release after level clear", 16'(pin_hiz), 16'h0);

        // R1 reset in the middle of operation
        reg_wr(A_SWREQ, 8'h1F);
        chk("R1 forced before reset", 16'(pin_hiz), 16'h3FF);
        rst_n = 1'b0;
        wait_n(1);
        chk("R1 reset releases pins", 16'(pin_hiz), 16'h0);
        rst_n = 1'b1;
        reg_rd(A_PINEN, rv);
        chk("R1 enables cleared", 16'(rv), 16'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule